// File: doc/BRIEF.md
# Address Table Placement Engine

The engine puts one unicast forwarding entry into an address table, or takes one out, in answer to a single command. The table itself lives outside the block in a synchronous-read memory that the engine walks one entry per cycle, starting at index 0 and going upward. An add command carries a 48-bit station address, a 12-bit VLAN id with a flag that says whether the id is part of the key, an egress port number and two attribute flags (secure and blocked). The engine chooses where to put the entry. An entry with the same key wins first. Failing that, the lowest empty slot is taken. Failing that, the lowest slot holding an evictable learned unicast entry is reused. If none of these exists the table is full and nothing is written.

A delete command uses the same key search. It clears the found slot to all zeros, which marks it empty, or reports that no such key exists. Commands enter through a valid/ready handshake: `cmd_ready` is high only while the engine is idle, so a held `cmd_valid` is back-pressured for the whole walk. Each command ends with a one-cycle `rsp_valid` pulse that carries the slot index and an error flag. Any table write happens in that same cycle. The response has no back-pressure.

Top module: `ate_engine`

## Requirements
- R1: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when the engine is idle. `busy` is high from the cycle after acceptance up to and including the response cycle, and `cmd_ready` is low during that time.
- R2: After acceptance the engine reads entries in ascending order, one per cycle, starting at index 0. The read address of cycle e (e = 0 is the cycle after the accepting edge) is e. Reads stop once the scan ends or the last index has been issued. Read data appears one cycle after the address.
- R3: A slot matches the key when its kind field (bits 61:60) is 1 or 3, its VLAN field (bits 59:48) equals the key VLAN, and bits 47:0 equal the address. The key VLAN is `cmd_vid` when `cmd_vlan` is 1 and 0 otherwise. A match at index k ends the scan. The response pulse then falls in cycle e = k+2. Without a match it falls in cycle e = ENTRIES+1.
- R4: An add whose key matches overwrites the matched slot, even when a lower empty slot exists.
- R5: An add without a match uses the lowest slot whose kind field is 0. It does so even when an evictable slot sits at a lower index.
- R6: When there is no match and no empty slot, an add uses the lowest evictable slot. A slot is evictable when its kind is 1 or 3, bit 40 (group address) is 0, and its age code in bits 63:62 is 1 or 3. Code 0 (pinned) and code 2 (vendor-prefix) are never evicted.
- R7: A written add entry has the address in bits 47:0, with the first address byte in bits 47:40. It has age code 0 in bits 63:62, secure in bit 64, blocked in bit 65 and the port number from bit 66 upward, ceil(log2(PORTS)) bits wide. With `cmd_vlan` = 1 the kind is 3 and bits 59:48 hold `cmd_vid`. Otherwise the kind is 1 and bits 59:48 are 0.
- R8: An add with no match, no empty slot and no evictable slot reports `rsp_err` = 1 and writes nothing.
- R9: A delete (`cmd_op` = 1) that matches writes an all-zero entry at the matched index, with `rsp_err` = 0. A delete with no match writes nothing and reports `rsp_err` = 1.
- R10: `rsp_valid` is high for exactly one cycle per command, with `rsp_index` set to the chosen slot. The single table write of a command happens in that cycle, with `mem_wr_addr` equal to `rsp_index`.
- R11: After reset the engine is idle: `cmd_ready` = 1, and `busy`, `rsp_valid`, `mem_rd_en` and `mem_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 1 | 0 add, 1 delete |
| cmd_mac | input | 48 | Station address, first byte in bits 47:40 |
| cmd_vid | input | 12 | VLAN id |
| cmd_vlan | input | 1 | VLAN id is part of the key |
| cmd_port | input | PW | Egress port number for an add |
| cmd_secure | input | 1 | Secure attribute for an add |
| cmd_blocked | input | 1 | Blocked attribute for an add |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_index | output | IW | Chosen slot |
| rsp_err | output | 1 | Table full (add) or key absent (delete) |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | IW | Table read index |
| mem_rd_data | input | EW | Table read data, one cycle after the address |
| mem_wr_en | output | 1 | Table write strobe |
| mem_wr_addr | output | IW | Table write index |
| mem_wr_data | output | EW | Table write data |

## Verification
The bench attacks the order of preference between slots. It places an evictable entry below an empty one, where a design that judged each slot on the spot would evict instead of filling the hole. It places an empty slot below an existing key, where such a design would create a duplicate. It also stores entries that look like the key but must not match: a VLAN-table kind with the same address bits, and a pinned key that differs only in VLAN id. A matcher that skipped the kind or VLAN check would overwrite or delete the wrong slot. Group-address, pinned and vendor-prefix entries fill a table with no evictable slot, so that a wrong age test shows up as a write where an error was due. Early termination is checked cycle by cycle against the expected read addresses and response cycle.

// File: rtl/ate_pkg.sv
package ate_pkg;
  typedef enum logic [1:0] {
    KIND_EMPTY = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_VTAB  = 2'd2,
    KIND_VADDR = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } eng_state_e;

  localparam int MAC_W    = 48;
  localparam int VID_W    = 12;
  localparam int GRP_BIT  = 40;
  localparam int VID_LSB  = 48;
  localparam int KIND_LSB = 60;
  localparam int AGE_LSB  = 62;
  localparam int SEC_BIT  = 64;
  localparam int BLK_BIT  = 65;
  localparam int PORT_LSB = 66;
  localparam int CLS_W    = 64;

  localparam logic CMD_ADD = 1'b0;
  localparam logic CMD_DEL = 1'b1;
endpackage

// File: rtl/ate_classify.sv
module ate_classify
  import ate_pkg::*;
(
  input  logic [CLS_W-1:0] entry,
  input  logic [MAC_W-1:0] key_mac,
  input  logic [VID_W-1:0] key_vid,
  output logic             hit,
  output logic             vacant,
  output logic             evictable
);
  localparam int NBYTE = MAC_W / 8;

  logic [NBYTE-1:0] byte_eq;
  logic [1:0]       kind;
  logic [1:0]       age;
  logic             is_addr;

  genvar b;
  generate
    for (b = 0; b < NBYTE; b++) begin : g_byte
      assign byte_eq[b] = (entry[b*8 +: 8] == key_mac[b*8 +: 8]);
    end
  endgenerate

  always_comb begin
    kind      = entry[KIND_LSB +: 2];
    age       = entry[AGE_LSB +: 2];
    is_addr   = (kind == KIND_ADDR) || (kind == KIND_VADDR);
    hit       = is_addr && (entry[VID_LSB +: VID_W] == key_vid) && (&byte_eq);
    vacant    = (kind == KIND_EMPTY);
    evictable = is_addr && !entry[GRP_BIT] && age[0];
  end
endmodule

// File: rtl/ate_first_pick.sv
module ate_first_pick #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          seen,
  input  logic          cand,
  input  logic [IW-1:0] idx,
  output logic          have_eff,
  output logic [IW-1:0] idx_eff
);
  logic          have_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      idx_q  <= '0;
    end else if (clr) begin
      have_q <= 1'b0;
      idx_q  <= '0;
    end else if (seen && cand && !have_q) begin
      have_q <= 1'b1;
      idx_q  <= idx;
    end
  end

  always_comb begin
    have_eff = have_q || (seen && cand);
    idx_eff  = have_q ? idx_q : idx;
  end

  a_r5_first_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && !clr) |=> (have_q && $stable(idx_q)));
endmodule

// File: rtl/ate_entry_build.sv
module ate_entry_build
  import ate_pkg::*;
#(
  parameter int PW = 3,
  parameter int EW = 69
) (
  input  logic [MAC_W-1:0] mac,
  input  logic [VID_W-1:0] vid,
  input  logic             vlan,
  input  logic [PW-1:0]    port,
  input  logic             secure,
  input  logic             blocked,
  output logic [EW-1:0]    entry
);
  always_comb begin
    entry                   = '0;
    entry[MAC_W-1:0]        = mac;
    entry[VID_LSB +: VID_W] = vlan ? vid : '0;
    entry[KIND_LSB +: 2]    = vlan ? KIND_VADDR : KIND_ADDR;
    entry[AGE_LSB +: 2]     = 2'b00;
    entry[SEC_BIT]          = secure;
    entry[BLK_BIT]          = blocked;
    entry[PORT_LSB +: PW]   = port;
  end
endmodule

// File: rtl/ate_engine.sv
module ate_engine
  import ate_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PORTS   = 6,
  localparam int IW     = $clog2(ENTRIES),
  localparam int PW     = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int EW     = PORT_LSB + PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_op,
  input  logic [MAC_W-1:0] cmd_mac,
  input  logic [VID_W-1:0] cmd_vid,
  input  logic             cmd_vlan,
  input  logic [PW-1:0]    cmd_port,
  input  logic             cmd_secure,
  input  logic             cmd_blocked,
  output logic             busy,
  output logic             rsp_valid,
  output logic [IW-1:0]    rsp_index,
  output logic             rsp_err,
  output logic             mem_rd_en,
  output logic [IW-1:0]    mem_rd_addr,
  input  logic [EW-1:0]    mem_rd_data,
  output logic             mem_wr_en,
  output logic [IW-1:0]    mem_wr_addr,
  output logic [EW-1:0]    mem_wr_data
);
  localparam logic [IW:0]   RA_END   = (IW+1)'(ENTRIES);
  localparam logic [IW-1:0] IDX_LAST = IW'(ENTRIES - 1);

  eng_state_e       st_q;
  logic [IW:0]      ra_q;
  logic             pend_q;
  logic [IW-1:0]    pidx_q;
  logic             op_q;
  logic [MAC_W-1:0] mac_q;
  logic [VID_W-1:0] vid_q;
  logic             vlan_q;
  logic [PW-1:0]    port_q;
  logic             sec_q;
  logic             blk_q;
  logic [IW-1:0]    res_idx_q;
  logic             res_err_q;
  logic             res_wr_q;

  logic             accept;
  logic             issue;
  logic             hit, vacant, evictable;
  logic             hit_now, last_now;
  logic             free_have, evict_have;
  logic [IW-1:0]    free_idx, evict_idx;
  logic [VID_W-1:0] key_vid;
  logic [EW-1:0]    new_entry;

  assign accept    = cmd_valid && (st_q == ST_IDLE);
  assign cmd_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign issue     = (st_q == ST_SCAN) && (ra_q < RA_END);
  assign key_vid   = vlan_q ? vid_q : '0;

  assign mem_rd_en   = issue;
  assign mem_rd_addr = ra_q[IW-1:0];

  ate_classify u_cls (
    .entry     (mem_rd_data[CLS_W-1:0]),
    .key_mac   (mac_q),
    .key_vid   (key_vid),
    .hit       (hit),
    .vacant    (vacant),
    .evictable (evictable)
  );

  assign hit_now  = (st_q == ST_SCAN) && pend_q && hit;
  assign last_now = (st_q == ST_SCAN) && pend_q && (pidx_q == IDX_LAST);

  ate_first_pick #(.IW(IW)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .seen     (pend_q && (st_q == ST_SCAN)),
    .cand     (vacant),
    .idx      (pidx_q),
    .have_eff (free_have),
    .idx_eff  (free_idx)
  );

  ate_first_pick #(.IW(IW)) u_evict (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .seen     (pend_q && (st_q == ST_SCAN)),
    .cand     (evictable),
    .idx      (pidx_q),
    .have_eff (evict_have),
    .idx_eff  (evict_idx)
  );

  ate_entry_build #(.PW(PW), .EW(EW)) u_build (
    .mac     (mac_q),
    .vid     (vid_q),
    .vlan    (vlan_q),
    .port    (port_q),
    .secure  (sec_q),
    .blocked (blk_q),
    .entry   (new_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ra_q      <= '0;
      pend_q    <= 1'b0;
      pidx_q    <= '0;
      op_q      <= CMD_ADD;
      mac_q     <= '0;
      vid_q     <= '0;
      vlan_q    <= 1'b0;
      port_q    <= '0;
      sec_q     <= 1'b0;
      blk_q     <= 1'b0;
      res_idx_q <= '0;
      res_err_q <= 1'b0;
      res_wr_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          pend_q <= 1'b0;
          if (accept) begin
            op_q   <= cmd_op;
            mac_q  <= cmd_mac;
            vid_q  <= cmd_vid;
            vlan_q <= cmd_vlan;
            port_q <= cmd_port;
            sec_q  <= cmd_secure;
            blk_q  <= cmd_blocked;
            ra_q   <= '0;
            st_q   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          pend_q <= issue;
          pidx_q <= ra_q[IW-1:0];
          if (issue) ra_q <= ra_q + 1'b1;
          if (hit_now) begin
            res_idx_q <= pidx_q;
            res_err_q <= 1'b0;
            res_wr_q  <= 1'b1;
            st_q      <= ST_DONE;
          end else if (last_now) begin
            st_q <= ST_DONE;
            if (op_q == CMD_DEL) begin
              res_idx_q <= '0;
              res_err_q <= 1'b1;
              res_wr_q  <= 1'b0;
            end else if (free_have) begin
              res_idx_q <= free_idx;
              res_err_q <= 1'b0;
              res_wr_q  <= 1'b1;
            end else if (evict_have) begin
              res_idx_q <= evict_idx;
              res_err_q <= 1'b0;
              res_wr_q  <= 1'b1;
            end else begin
              res_idx_q <= '0;
              res_err_q <= 1'b1;
              res_wr_q  <= 1'b0;
            end
          end
        end
        ST_DONE: begin
          pend_q <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid   = (st_q == ST_DONE);
  assign rsp_index   = res_idx_q;
  assign rsp_err     = res_err_q;
  assign mem_wr_en   = (st_q == ST_DONE) && res_wr_q;
  assign mem_wr_addr = res_idx_q;
  assign mem_wr_data = (op_q == CMD_DEL) ? '0 : new_entry;

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r10_write_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (rsp_valid && (mem_wr_addr == rsp_index)));
  a_r8_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !mem_wr_en);
  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  a_r1_rsp_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);
  a_r2_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1));
  a_r2_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !mem_rd_en);
endmodule

// File: tb/sim_ate_engine.sv
module sim_ate_engine;
  localparam int N  = 16;
  localparam int P  = 6;
  localparam int IW = 4;
  localparam int PW = 3;
  localparam int EW = 66 + PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_op = 1'b0;
  logic [47:0]   cmd_mac = '0;
  logic [11:0]   cmd_vid = '0;
  logic          cmd_vlan = 1'b0;
  logic [PW-1:0] cmd_port = '0;
  logic          cmd_secure = 1'b0;
  logic          cmd_blocked = 1'b0;
  logic          busy, rsp_valid, rsp_err;
  logic [IW-1:0] rsp_index;
  logic          mem_rd_en, mem_wr_en;
  logic [IW-1:0] mem_rd_addr, mem_wr_addr;
  logic [EW-1:0] mem_rd_data = '0;
  logic [EW-1:0] mem_wr_data;

  logic [EW-1:0] mem    [N];
  logic [EW-1:0] ld_mem [N];
  logic          ld_go = 1'b0;

  int n_run  = 0;
  int n_fail = 0;
  bit done_all = 1'b0;

  always #5 clk = ~clk;

  ate_engine #(.ENTRIES(N), .PORTS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mac(cmd_mac), .cmd_vid(cmd_vid), .cmd_vlan(cmd_vlan),
    .cmd_port(cmd_port), .cmd_secure(cmd_secure), .cmd_blocked(cmd_blocked),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_index(rsp_index), .rsp_err(rsp_err),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  always @(posedge clk) begin
    if (ld_go) begin
      for (int i = 0; i < N; i++) mem[i] <= ld_mem[i];
    end else if (mem_wr_en) begin
      mem[mem_wr_addr] <= mem_wr_data;
    end
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
  end

  task automatic chk(input bit ok, input string rq, input logic [95:0] act, input logic [95:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [EW-1:0] mk(input int kind, input int age, input logic [11:0] vid, input logic [47:0] mac);
    logic [EW-1:0] v;
    v = '0;
    v[47:0]  = mac;
    v[59:48] = vid;
    v[61:60] = 2'(kind);
    v[63:62] = 2'(age);
    return v;
  endfunction

  function automatic int ref_match(input logic [47:0] mac, input logic [11:0] vid);
    for (int i = 0; i < N; i++) begin
      if ((mem[i][61:60] == 2'd1 || mem[i][61:60] == 2'd3) &&
          mem[i][59:48] == vid && mem[i][47:0] == mac) return i;
    end
    return -1;
  endfunction

  task automatic preload();
    @(negedge clk);
    ld_go = 1'b1;
    @(negedge clk);
    ld_go = 1'b0;
  endtask

  // want < 0 means an error response is expected
  task automatic run(input bit del, input logic [47:0] mac, input logic [11:0] vid, input bit vlan,
                     input int port, input bit sec, input bit blk, input int want, input string rq);
    int m, done_e;
    bit wr_exp;
    logic [EW-1:0] exp_data;
    m = ref_match(mac, vlan ? vid : 12'd0);
    done_e = ((m >= 0) ? m : N - 1) + 2;
    wr_exp = (want >= 0);
    if (del) exp_data = '0;
    else begin
      exp_data = mk(vlan ? 3 : 1, 0, vlan ? vid : 12'd0, mac);
      exp_data[64] = sec;
      exp_data[65] = blk;
      exp_data[66 +: PW] = PW'(port);
    end
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", 96'(cmd_ready), 96'd1);
    cmd_valid = 1'b1; cmd_op = del; cmd_mac = mac; cmd_vid = vid; cmd_vlan = vlan;
    cmd_port = PW'(port); cmd_secure = sec; cmd_blocked = blk;
    for (int e = 0; e <= done_e; e++) begin
      @(negedge clk);
      if (e == 0) cmd_valid = 1'b0;
      chk(busy == 1'b1 && cmd_ready == 1'b0, "R1", 96'({busy, cmd_ready}), 96'b10);
      chk(mem_rd_en == (e <= done_e - 1 && e < N), "R2", 96'(mem_rd_en), 96'(e <= done_e - 1 && e < N));
      if (mem_rd_en) chk(mem_rd_addr == IW'(e), "R2", 96'(mem_rd_addr), 96'(e));
      chk(rsp_valid == (e == done_e), "R3", 96'(rsp_valid), 96'(e == done_e));
      chk(mem_wr_en == (e == done_e && wr_exp), "R10", 96'(mem_wr_en), 96'(e == done_e && wr_exp));
      if (e == done_e) begin
        chk(rsp_err == !wr_exp, rq, 96'(rsp_err), 96'(!wr_exp));
        if (wr_exp) begin
          chk(rsp_index == IW'(want), rq, 96'(rsp_index), 96'(want));
          chk(mem_wr_addr == IW'(want), "R10", 96'(mem_wr_addr), 96'(want));
          chk(mem_wr_data == exp_data, del ? "R9" : "R7", 96'(mem_wr_data), 96'(exp_data));
        end
      end
    end
    @(negedge clk);
    chk(busy == 1'b0 && cmd_ready == 1'b1 && rsp_valid == 1'b0, "R10", 96'({busy, cmd_ready, rsp_valid}), 96'b010);
  endtask

  localparam logic [47:0] MAC_A = 48'h0200_0000_0011;
  localparam logic [47:0] MAC_B = 48'h0200_0000_0022;
  localparam logic [47:0] MAC_C = 48'h0200_0000_0033;
  localparam logic [47:0] MAC_D = 48'h0600_0000_0077;
  localparam logic [47:0] MAC_E = 48'h0600_0000_0088;
  localparam logic [47:0] MAC_F = 48'h0600_0000_0099;

  initial begin
    for (int i = 0; i < N; i++) begin
      mem[i] = '0;
      ld_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && busy == 1'b0 && rsp_valid == 1'b0 && mem_rd_en == 1'b0 && mem_wr_en == 1'b0,
        "R11", 96'({cmd_ready, busy, rsp_valid, mem_rd_en, mem_wr_en}), 96'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1 && busy == 1'b0, "R11", 96'({cmd_ready, busy}), 96'b10);

    run(0, MAC_A, 12'd0, 0, 2, 0, 0, 0, "R5");
    run(0, MAC_B, 12'd5, 1, 4, 1, 0, 1, "R7");
    run(0, MAC_A, 12'd9, 0, 5, 0, 1, 0, "R4");   // no VLAN key: vid ignored, matches slot 0
    run(0, MAC_A, 12'd5, 1, 1, 0, 0, 2, "R3");   // VLAN 5 key differs from slot 0
    run(1, MAC_B, 12'd5, 1, 0, 0, 0, 1, "R9");
    run(1, MAC_B, 12'd5, 1, 0, 0, 0, -1, "R9");
    run(0, MAC_C, 12'd0, 0, 3, 1, 1, 1, "R5");

    // full table: pinned, vendor-prefix, group, VLAN-table kinds; first evictable at 9
    for (int i = 0; i < N; i++) ld_mem[i] = mk(1, 0, 12'd0, 48'h0400_0000_0100 + 48'(i));
    ld_mem[2]  = mk(1, 2, 12'd0, 48'h0400_0000_0102);
    ld_mem[3]  = mk(2, 1, 12'd0, MAC_F);
    ld_mem[4]  = mk(1, 3, 12'd0, 48'h0500_0000_0104);
    ld_mem[6]  = mk(3, 2, 12'd9, 48'h0400_0000_0106);
    ld_mem[9]  = mk(1, 1, 12'd0, 48'h0400_0000_0109);
    ld_mem[12] = mk(3, 3, 12'd9, 48'h0400_0000_010c);
    preload();
    run(0, MAC_D, 12'd0, 0, 1, 0, 0, 9, "R6");
    run(1, MAC_F, 12'd0, 0, 0, 0, 0, -1, "R3"); // VLAN-table kind never matches

    for (int i = 0; i < N; i++) ld_mem[i] = mem[i];
    ld_mem[14] = '0;
    preload();
    run(0, MAC_E, 12'd0, 0, 2, 0, 0, 14, "R5"); // empty 14 beats evictable 12

    for (int i = 0; i < N; i++) ld_mem[i] = mem[i];
    ld_mem[12] = mk(3, 0, 12'd9, 48'h0400_0000_010c);
    preload();
    run(0, MAC_F, 12'd0, 0, 4, 0, 0, -1, "R8");
    run(0, 48'h0400_0000_010c, 12'd9, 1, 2, 0, 0, 12, "R4");

    for (int i = 0; i < N; i++) ld_mem[i] = mem[i];
    ld_mem[0] = '0;
    preload();
    run(0, 48'h0400_0000_0105, 12'd0, 0, 1, 1, 0, 5, "R4"); // match beats lower empty slot

    done_all = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_all) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule